// File: doc/BRIEF.md
# Programmable Shortened Reed-Solomon Encoder

This block is a systematic Reed-Solomon encoder over GF(2^8) with sixteen check symbols, so it corrects up to eight symbol errors per codeword. It accepts one 8-bit message symbol per clock through a valid/ready input. It sends each message symbol to the output stream unchanged and then appends sixteen parity symbols, which it computes with a pipelined remainder register whose tap constants are derived at elaboration.

The codeword length n is taken from a configuration input when the first symbol of each block is accepted. This gives a shortened code whose message length is n minus 16. Software can change n freely, and the new value applies from the next block.

A bypass mode turns encoding off so that symbols stream through with the same two-stage latency and no parity is added. A single-cycle last flag marks the final parity symbol of each codeword.

Top module: `rs_shortened_enc`

## Requirements
- R1: The first n-16 output symbols of a codeword equal the accepted message symbols, in the order they were accepted.
- R2: The sixteen symbols that follow the message make a codeword c(x) that vanishes at alpha^0 through alpha^15. Here alpha is 0x02, the field polynomial is x^8+x^4+x^3+x^2+1 (0x11D), and the first output symbol is the coefficient of the highest degree.
- R3: The codeword length n is sampled from `cfg_n_i` when the first message symbol of a block is accepted. Values below 50 are treated as 50, and the block holds n-16 message symbols.
- R4: Changes to `cfg_n_i` after the first symbol of a block have no effect on that block's length.
- R5: A symbol accepted at a rising edge appears on `out_data_o` with `out_valid_o` high after the next rising edge, which is two register stages from input to output.
- R6: `in_ready_o` stays high for every message symbol of a block. It goes low right after the last message symbol is accepted and stays low for exactly 17 cycles while the parity symbols are sent.
- R7: `out_last_o` is high for exactly one cycle, together with the final parity symbol, and at no other time.
- R8: When `bypass_i` is high while no block is in progress, each accepted symbol passes through unchanged with the R5 latency. No parity is added and no last flag is raised. If `bypass_i` is raised in the middle of a block, it has no effect on that block.
- R9: The remainder is cleared after each codeword, so every block is encoded independently of the blocks before it.
- R10: While reset is active, and after it is released, `out_valid_o` and `out_last_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_n_i | input | 8 | Codeword length n for the next block |
| bypass_i | input | 1 | Pass symbols through with no encoding |
| in_valid_i | input | 1 | Input symbol valid |
| in_data_i | input | 8 | Input symbol |
| in_ready_o | output | 1 | Encoder can accept a symbol |
| out_valid_o | output | 1 | Output symbol valid |
| out_data_o | output | 8 | Output symbol (message or parity) |
| out_last_o | output | 1 | Final parity symbol of a codeword |

## Verification
An error in a remainder tap, or a remainder left uncleared between blocks, does not show up until parity is sent. It then appears as nonzero syndromes, or as nonzero parity for an all-zero message, within the 16 cycles that follow the last message symbol. A message counter or length capture that is off by one moves the ready stall and the last flag by a cycle, and this shows at the ports during the block itself. A broken data path or a mishandled bypass shows on the output two register stages after the symbol is accepted.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W-1:0] POLY_LO = 8'h1D;  // x^8+x^4+x^3+x^2+1
  localparam int MAX_PAR = 32;

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] r;
    logic [SYM_W-1:0] x;
    r = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) r = r ^ x;
      x = x[SYM_W-1] ? ({x[SYM_W-2:0], 1'b0} ^ POLY_LO) : {x[SYM_W-2:0], 1'b0};
    end
    return r;
  endfunction

  // coefficient idx of prod_{i<npar} (x + alpha^i)
  function automatic logic [SYM_W-1:0] gen_coef(input int npar, input int idx);
    logic [SYM_W-1:0] g [0:MAX_PAR];
    logic [SYM_W-1:0] root;
    for (int k = 0; k <= MAX_PAR; k++) g[k] = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < npar; i++) begin
      for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 8'h02);
    end
    return g[idx];
  endfunction
endpackage

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int NPAR  = 16,
  parameter int N_MIN = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] cfg_n_i,
  input  logic             bypass_i,
  input  logic             in_valid_i,
  input  logic             done_i,
  output logic             in_ready_o,
  output logic             acc_o,
  output logic             acc_byp_o,
  output logic             acc_end_o
);
  localparam logic [SYM_W-1:0] NMIN_V = SYM_W'(N_MIN);
  localparam logic [SYM_W-1:0] NPAR_V = SYM_W'(NPAR);

  logic [SYM_W-1:0] msg_cnt_q, k_cur_q, n_eff, k_new, k_use;
  logic             busy_q, at_start, byp;

  assign n_eff    = (cfg_n_i < NMIN_V) ? NMIN_V : cfg_n_i;
  assign k_new    = n_eff - NPAR_V;
  assign at_start = (msg_cnt_q == '0);
  assign k_use    = at_start ? k_new : k_cur_q;
  assign byp      = at_start & bypass_i;

  assign in_ready_o = ~busy_q;
  assign acc_o      = in_valid_i & ~busy_q;
  assign acc_byp_o  = byp;
  assign acc_end_o  = acc_o & ~byp & (msg_cnt_q == k_use - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_cnt_q <= '0;
      k_cur_q   <= '0;
      busy_q    <= 1'b0;
    end else begin
      if (acc_o && !byp) begin
        msg_cnt_q <= acc_end_o ? '0 : msg_cnt_q + 1'b1;
        if (at_start) k_cur_q <= k_new;
      end
      if (acc_end_o)   busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_enc_rem.sv
module rs_enc_rem
  import rs_enc_pkg::*;
#(
  parameter int NPAR = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [SYM_W-1:0] top_o
);
  logic [NPAR*SYM_W-1:0] rem_flat;
  logic [SYM_W-1:0]      fb;

  assign top_o = rem_flat[NPAR*SYM_W-1 -: SYM_W];
  assign fb    = sym_i ^ top_o;

  for (genvar i = 0; i < NPAR; i++) begin : g_tap
    localparam logic [SYM_W-1:0] COEF = gen_coef(NPAR, i);
    logic [SYM_W-1:0] q, prev, prod;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = rem_flat[(i-1)*SYM_W +: SYM_W];
    end
    assign prod = gf_mul(fb, COEF);
    assign rem_flat[i*SYM_W +: SYM_W] = q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (load_i)  q <= prev ^ prod;
      else if (shift_i) q <= prev;  // drains to zero over NPAR shifts
    end
  end
endmodule

// File: rtl/rs_enc_seq.sv
module rs_enc_seq
  import rs_enc_pkg::*;
#(
  parameter int NPAR = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             acc_byp_i,
  input  logic             acc_end_i,
  input  logic [SYM_W-1:0] data_i,
  input  logic [SYM_W-1:0] rem_top_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             done_o,
  output logic [SYM_W-1:0] sym_o,
  output logic             out_valid_o,
  output logic [SYM_W-1:0] out_data_o,
  output logic             out_last_o
);
  localparam int PC_W = $clog2(NPAR);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(NPAR - 1);

  logic             s1_v, s1_byp, s1_end;
  logic [SYM_W-1:0] s1_d;
  logic             par_act;
  logic [PC_W-1:0]  par_cnt;

  assign load_o  = s1_v & ~s1_byp;
  assign shift_o = par_act;
  assign done_o  = par_act & (par_cnt == PC_LAST);
  assign sym_o   = s1_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_byp <= 1'b0; s1_end <= 1'b0; s1_d <= '0;
    end else begin
      s1_v   <= acc_i;
      s1_byp <= acc_byp_i;
      s1_end <= acc_end_i;
      if (acc_i) s1_d <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_act <= 1'b0;
      par_cnt <= '0;
    end else if (s1_v && s1_end) begin
      par_act <= 1'b1;
      par_cnt <= '0;
    end else if (par_act) begin
      if (done_o) par_act <= 1'b0;
      par_cnt <= par_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else begin
      out_valid_o <= s1_v | par_act;
      out_data_o  <= par_act ? rem_top_i : s1_d;
      out_last_o  <= done_o;
    end
  end
endmodule

// File: rtl/rs_shortened_enc.sv
module rs_shortened_enc
  import rs_enc_pkg::*;
#(
  parameter int NPAR  = 16,
  parameter int N_MIN = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] cfg_n_i,
  input  logic             bypass_i,
  input  logic             in_valid_i,
  input  logic [SYM_W-1:0] in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [SYM_W-1:0] out_data_o,
  output logic             out_last_o
);
  logic             acc, acc_byp, acc_end, load, shift, done;
  logic [SYM_W-1:0] sym, rem_top;

  rs_enc_ctrl #(.NPAR(NPAR), .N_MIN(N_MIN)) u_ctrl (
    .clk_i, .rst_ni, .cfg_n_i, .bypass_i, .in_valid_i,
    .done_i(done), .in_ready_o,
    .acc_o(acc), .acc_byp_o(acc_byp), .acc_end_o(acc_end)
  );

  rs_enc_seq #(.NPAR(NPAR)) u_seq (
    .clk_i, .rst_ni,
    .acc_i(acc), .acc_byp_i(acc_byp), .acc_end_i(acc_end),
    .data_i(in_data_i), .rem_top_i(rem_top),
    .load_o(load), .shift_o(shift), .done_o(done), .sym_o(sym),
    .out_valid_o, .out_data_o, .out_last_o
  );

  rs_enc_rem #(.NPAR(NPAR)) u_rem (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift),
    .sym_i(sym), .top_o(rem_top)
  );
endmodule

// File: rtl/rs_shortened_enc_chk.sv
module rs_shortened_enc_chk #(
  parameter int NPAR = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic [7:0] in_data_i,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_last_o
);
  logic [1:0] age;
  int unsigned stall_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age <= '0;
      stall_cnt <= 0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      stall_cnt <= in_ready_o ? 0 : stall_cnt + 1;
    end
  end

  a_r5_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && $past(in_valid_i && in_ready_o, 2))
      |-> (out_valid_o && out_data_o == $past(in_data_i, 2)));

  a_r7_last_is_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  a_r7_last_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> !out_last_o);

  a_r6_stall_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1 && $fell(in_ready_o)) |-> $past(in_valid_i));

  a_r6_stall_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_cnt <= NPAR + 1);
endmodule

bind rs_shortened_enc rs_shortened_enc_chk #(.NPAR(NPAR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .in_data_i(in_data_i), .out_valid_o(out_valid_o),
  .out_data_o(out_data_o), .out_last_o(out_last_o)
);

// File: tb/rs_shortened_enc_bench.sv
`timescale 1ns/1ps
module rs_shortened_enc_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cfg_n_i = 8'd255;
  logic       bypass_i = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_ready_o, out_valid_o, out_last_o;
  logic [7:0] out_data_o;

  rs_shortened_enc u_rs_shortened_enc (.*);

  always #4 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] cap_d [0:511];
  int cap_cnt = 0, last_cnt = 0, last_idx = -1;
  logic [7:0] msg [0:255];

  // {cfg_n, expected n, seed}
  localparam logic [23:0] VEC [0:5] = '{
    {8'd255, 8'd255, 8'd3},  {8'd50, 8'd50, 8'd5},   {8'd20, 8'd50, 8'd9},
    {8'd0,   8'd50,  8'd11}, {8'd100, 8'd100, 8'd17}, {8'd239, 8'd239, 8'd23}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = '0;
    logic [7:0] y = b;
    for (int i = 7; i >= 0; i--) begin
      r = r[7] ? ({r[6:0], 1'b0} ^ 8'h1D) : {r[6:0], 1'b0};
      if (a[i]) r = r ^ y;
    end
    return r;
  endfunction

  function automatic logic [7:0] apow(input int j);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < j; i++) r = bmul(r, 8'h02);
    return r;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && cap_cnt < 512) begin
      cap_d[cap_cnt] = out_data_o;
      if (out_last_o) begin last_cnt++; last_idx = cap_cnt; end
      cap_cnt++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R6 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_cap();
    cap_cnt = 0; last_cnt = 0; last_idx = -1;
  endtask

  task automatic encode_block(input int cfg, input int exp_n, input int seed,
                              input bit zero, input int chg_at, input int alt_cfg,
                              input bit alt_byp, input string len_req);
    int k = exp_n - 16;
    int i = 0, stalls = 0, low = 0;
    bit acc;
    bit syn_ok = 1'b1;
    bit dat_ok = 1'b1;
    bit par_zero = 1'b1;
    for (int m = 0; m < k; m++) msg[m] = zero ? 8'h00 : 8'((seed * 7 + m * 13 + m * m) & 255);
    clear_cap();
    cfg_n_i = 8'(cfg);
    bypass_i = 1'b0;
    while (i < k) begin
      @(negedge clk_i);
      if (i == chg_at) begin cfg_n_i = 8'(alt_cfg); bypass_i = alt_byp; end
      in_valid_i = 1'b1;
      in_data_i = msg[i];
      acc = in_ready_o;
      if (!acc) stalls++;
      @(posedge clk_i);
      if (acc) i++;
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    while (!in_ready_o && low < 100) begin low++; @(negedge clk_i); end
    cfg_n_i = 8'd255;
    bypass_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(stalls == 0, "R6", "stalls during message", stalls, 0);
    chk(low == 17, "R6", "ready low cycles", low, 17);
    chk(cap_cnt == exp_n, len_req, "codeword length", cap_cnt, exp_n);
    for (int m = 0; m < k; m++) if (cap_d[m] != msg[m]) dat_ok = 1'b0;
    chk(dat_ok, "R1", "message symbols", int'(dat_ok), 1);
    for (int j = 0; j < 16; j++) begin
      logic [7:0] r = apow(j);
      logic [7:0] s = '0;
      for (int m = 0; m < exp_n; m++) s = bmul(s, r) ^ cap_d[m];
      if (s != 0) syn_ok = 1'b0;
    end
    chk(syn_ok, "R2", "syndromes zero", int'(syn_ok), 1);
    chk(last_cnt == 1 && last_idx == exp_n - 1, "R7", "last flag index", last_idx, exp_n - 1);
    if (zero) begin
      for (int m = k; m < exp_n; m++) if (cap_d[m] != 0) par_zero = 1'b0;
      chk(par_zero, "R9", "zero message parity after prior block", int'(par_zero), 1);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk(!out_valid_o, "R10", "valid in reset", int'(out_valid_o), 0);
    chk(in_ready_o, "R10", "ready in reset", int'(in_ready_o), 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!out_valid_o && !out_last_o, "R10", "idle after reset", int'(out_valid_o), 0);

    for (int v = 0; v < 6; v++) begin
      encode_block(int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]),
                   1'b0, -1, 0, 1'b0, "R3");
    end

    encode_block(60, 60, 31, 1'b1, -1, 0, 1'b0, "R3");
    encode_block(60, 60, 41, 1'b0, 10, 120, 1'b0, "R4");
    encode_block(70, 70, 43, 1'b0, 12, 70, 1'b1, "R8");

    // R8: bypass streaming
    clear_cap();
    bypass_i = 1'b1;
    for (int m = 0; m < 6; m++) begin
      @(negedge clk_i);
      chk(in_ready_o, "R8", "ready in bypass", int'(in_ready_o), 1);
      in_valid_i = 1'b1;
      in_data_i = 8'(8'hA0 + m);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk(cap_cnt == 6, "R8", "bypass output count", cap_cnt, 6);
    for (int m = 0; m < 6; m++)
      chk(cap_d[m] == 8'(8'hA0 + m), "R8", "bypass data", int'(cap_d[m]), 8'hA0 + m);
    chk(last_cnt == 0, "R8", "no last in bypass", last_cnt, 0);

    // R5: latency
    in_valid_i = 1'b1;
    in_data_i = 8'h5C;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(!out_valid_o, "R5", "valid one edge after accept", int'(out_valid_o), 0);
    @(negedge clk_i);
    chk(out_valid_o && out_data_o == 8'h5C, "R5", "data after second edge", int'(out_data_o), 8'h5C);
    bypass_i = 1'b0;
    repeat (3) @(negedge clk_i);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule